// File: doc/BRIEF.md
# Host-to-Microcontroller Byte Mailbox

This block links a host processor bus to the three 8-bit parallel ports of a small microcontroller. Two one-byte mailboxes carry data, one in each direction, and two flags track their state. The *accept* flag says the microcontroller has taken the last host byte. The *ready* flag says the host has collected the last reply. The host side has three registers: a data register (write sends a byte, read collects the reply), a status register, and a handshake-clear register whose read forces both flags to their idle state.

The microcontroller side models ports A, B and C, each with an output register and a data-direction register. Port A carries data in both directions. The microcontroller moves bytes by toggling two port B output bits. The flags appear on port C inputs with polarities chosen for the firmware polling loop: accept is reported inverted and ready is reported true. The block also drives the microcontroller interrupt request, which is asserted exactly while a host byte waits to be accepted. The microcontroller core is not part of the block.

Top module: `mbx_cpu_mcu_bridge`

## Requirements
- R1: After reset all direction registers, output registers and mailboxes are 0, ready=1, accept=1, and mcu_irq=0; status reads 0x03 and port C reads 0x02.
- R2: A host write to register 0 stores the byte in the inbound mailbox, clears accept and raises mcu_irq from the next cycle.
- R3: A microcontroller write to port B (address 1) with direction bit 1 set and data bit 1 low copies the inbound mailbox into the port A input latch; with direction bit 1 clear nothing is copied.
- R4: A port B write that turns bit 1 from 0 to 1, compared against the previously written port B output value, with direction bit 1 set, sets accept and drops mcu_irq; with direction bit 1 clear it has no effect.
- R5: A port B write that turns bit 2 from 0 to 1, with direction bit 2 set, captures the port A output register into the outbound mailbox and clears ready.
- R6: A host read of register 0 returns the outbound mailbox and sets ready.
- R7: Port C input bit 0 reads 1 while accept is 0, input bit 1 reads 1 while ready is 1, other input bits read 0.
- R8: A microcontroller read of port A, B or C (addresses 0, 1, 2) returns the output register bit where the direction bit is 1 and the input bit where it is 0; direction registers are written at addresses 4, 5, 6.
- R9: A host read of register 1 returns ready in bit 0, accept in bit 1, and 0 in bits 7..2.
- R10: A host read of register 2 returns 0xFF, sets ready and accept, and drops mcu_irq.
- R11: When a host write and an accept edge fall in the same cycle, the host write wins: accept ends 0 and mcu_irq ends 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (read side effects) |
| host_addr | input | 2 | Host register select: 0 data, 1 status, 2 handshake clear |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |
| mcu_we | input | 1 | Microcontroller port register write strobe |
| mcu_addr | input | 3 | Port register select: 0..2 ports A..C, 4..6 their direction registers |
| mcu_wdata | input | 8 | Microcontroller write data |
| mcu_rdata | output | 8 | Microcontroller port read data (combinational) |
| mcu_irq | output | 1 | Interrupt request to the microcontroller, active high |

## Verification
The hardest state to reach is the same-cycle collision of a host write with the microcontroller's accept edge, since the two sides normally alternate. The stimulus first parks port B bit 1 low with its direction set, then drives a host data write and the port B write that raises bit 1 in one cycle and reads status and the interrupt afterwards. Edges that must be ignored because the direction bit is clear are reached by clearing the port B direction register after a full transfer and repeating the low-then-high sequence, then reading port A and status to show neither the input latch nor accept moved.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    HREG_DATA  = 2'd0,
    HREG_STAT  = 2'd1,
    HREG_CLEAR = 2'd2
  } host_reg_e;

  typedef enum logic [2:0] {
    MREG_PA  = 3'd0,
    MREG_PB  = 3'd1,
    MREG_PC  = 3'd2,
    MREG_DA  = 3'd4,
    MREG_DB  = 3'd5,
    MREG_DC  = 3'd6
  } mcu_reg_e;
endpackage

// File: rtl/mbx_port_file.sv
module mbx_port_file #(
  parameter int DW       = 8,
  parameter int NPORT    = 3,
  parameter int AW       = 3,
  parameter int DATA_IDX = 0,
  parameter int CTL_IDX  = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       wdata,
  input  logic [NPORT*DW-1:0] pin_in,
  output logic [DW-1:0]       rdata,
  output logic [DW-1:0]       data_out,
  output logic [DW-1:0]       ctl_out,
  output logic [DW-1:0]       ctl_ddr
);
  localparam int DDR_BASE = 1 << (AW - 1);

  logic [DW-1:0] mixed   [NPORT];
  logic [DW-1:0] out_arr [NPORT];
  logic [DW-1:0] ddr_arr [NPORT];

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic          hit_out, hit_ddr;
    logic [DW-1:0] out_d, ddr_d, out_r, ddr_r;

    assign hit_out = we && (addr == AW'(p));
    assign hit_ddr = we && (addr == AW'(DDR_BASE + p));

    always_comb begin
      out_d = out_r;
      ddr_d = ddr_r;
      if (hit_out) out_d = wdata;
      if (hit_ddr) ddr_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_r <= '0;
        ddr_r <= '0;
      end else begin
        out_r <= out_d;
        ddr_r <= ddr_d;
      end
    end

    assign out_arr[p] = out_r;
    assign ddr_arr[p] = ddr_r;
    assign mixed[p]   = (out_r & ddr_r) | (pin_in[p*DW +: DW] & ~ddr_r);
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NPORT; i++) begin
      if (addr == AW'(i)) rdata = mixed[i];
    end
  end

  assign data_out = out_arr[DATA_IDX];
  assign ctl_out  = out_arr[CTL_IDX];
  assign ctl_ddr  = ddr_arr[CTL_IDX];
endmodule

// File: rtl/mbx_handshake.sv
module mbx_handshake #(
  parameter int DW      = 8,
  parameter int STB_IN  = 1,
  parameter int STB_OUT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_put,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_take,
  input  logic          host_clear,
  input  logic          ctl_we,
  input  logic [DW-1:0] ctl_wdata,
  input  logic [DW-1:0] ctl_prev,
  input  logic [DW-1:0] ctl_ddr,
  input  logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_in_q,
  output logic [DW-1:0] outbox_q,
  output logic          ready_q,
  output logic          accept_q
);
  logic [DW-1:0] inbox_q, inbox_d, pa_in_d, outbox_d;
  logic          ready_d, accept_d;
  logic          load_low, in_rise, out_rise;

  // strobe decode against the previously written port B value
  assign load_low = ctl_we && ctl_ddr[STB_IN] && !ctl_wdata[STB_IN];
  assign in_rise  = ctl_we && ctl_ddr[STB_IN] && !ctl_prev[STB_IN] && ctl_wdata[STB_IN];
  assign out_rise = ctl_we && ctl_ddr[STB_OUT] && !ctl_prev[STB_OUT] && ctl_wdata[STB_OUT];

  always_comb begin
    inbox_d  = host_put ? host_wdata : inbox_q;
    pa_in_d  = load_low ? inbox_q : pa_in_q;
    outbox_d = out_rise ? pa_out : outbox_q;
    // host write has priority over the accept edge (R11)
    if (host_put)                  accept_d = 1'b0;
    else if (in_rise || host_clear) accept_d = 1'b1;
    else                           accept_d = accept_q;
    if (host_take || host_clear)   ready_d = 1'b1;
    else if (out_rise)             ready_d = 1'b0;
    else                           ready_d = ready_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inbox_q  <= '0;
      pa_in_q  <= '0;
      outbox_q <= '0;
      ready_q  <= 1'b1;
      accept_q <= 1'b1;
    end else begin
      inbox_q  <= inbox_d;
      pa_in_q  <= pa_in_d;
      outbox_q <= outbox_d;
      ready_q  <= ready_d;
      accept_q <= accept_d;
    end
  end

  p_put_clears_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_put |=> !accept_q);

  p_low_copies_inbox_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_low |=> (pa_in_q == $past(inbox_q)));

  p_rise_sets_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rise && !host_put) |=> accept_q);

  p_capture_outbox_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_rise && !host_take && !host_clear) |=> (!ready_q && outbox_q == $past(pa_out)));

  p_clear_idles_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_clear && !host_put) |=> (ready_q && accept_q));
endmodule

// File: rtl/mbx_cpu_mcu_bridge.sv
module mbx_cpu_mcu_bridge
  import mbx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [1:0]    host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          mcu_we,
  input  logic [2:0]    mcu_addr,
  input  logic [DW-1:0] mcu_wdata,
  output logic [DW-1:0] mcu_rdata,
  output logic          mcu_irq
);
  localparam int NPORT = 3;

  logic [1:0]          rst_sync;
  logic                rst_n_i;
  logic                host_put, host_take, host_clear, ctl_we;
  logic [DW-1:0]       pa_in_q, outbox_q, data_out, ctl_out, ctl_ddr, pc_in;
  logic                ready_q, accept_q;
  logic [NPORT*DW-1:0] pin_in;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  assign host_put   = host_wr && (host_addr == HREG_DATA);
  assign host_take  = host_rd && (host_addr == HREG_DATA);
  assign host_clear = host_rd && (host_addr == HREG_CLEAR);
  assign ctl_we     = mcu_we && (mcu_addr == MREG_PB);

  always_comb begin
    pc_in    = '0;
    pc_in[0] = ~accept_q;
    pc_in[1] = ready_q;
  end
  assign pin_in = {pc_in, {DW{1'b0}}, pa_in_q};

  mbx_port_file #(.DW(DW), .NPORT(NPORT), .AW(3), .DATA_IDX(0), .CTL_IDX(1)) u_ports (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .we       (mcu_we),
    .addr     (mcu_addr),
    .wdata    (mcu_wdata),
    .pin_in   (pin_in),
    .rdata    (mcu_rdata),
    .data_out (data_out),
    .ctl_out  (ctl_out),
    .ctl_ddr  (ctl_ddr)
  );

  mbx_handshake #(.DW(DW), .STB_IN(1), .STB_OUT(2)) u_hs (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .host_put   (host_put),
    .host_wdata (host_wdata),
    .host_take  (host_take),
    .host_clear (host_clear),
    .ctl_we     (ctl_we),
    .ctl_wdata  (mcu_wdata),
    .ctl_prev   (ctl_out),
    .ctl_ddr    (ctl_ddr),
    .pa_out     (data_out),
    .pa_in_q    (pa_in_q),
    .outbox_q   (outbox_q),
    .ready_q    (ready_q),
    .accept_q   (accept_q)
  );

  always_comb begin
    case (host_addr)
      HREG_DATA:  host_rdata = outbox_q;
      HREG_STAT:  host_rdata = {{(DW-2){1'b0}}, accept_q, ready_q};
      HREG_CLEAR: host_rdata = {DW{1'b1}};
      default:    host_rdata = '0;
    endcase
  end

  // interrupt pending exactly while a host byte is not yet accepted
  assign mcu_irq = ~accept_q;

  p_irq_after_clear_r10: assert property (@(posedge clk) disable iff (!rst_n_i)
    (host_clear && !host_put) |=> !mcu_irq);
endmodule

// File: tb/mbx_cpu_mcu_bridge_tb.sv
module mbx_cpu_mcu_bridge_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [1:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       mcu_we = 1'b0;
  logic [2:0] mcu_addr = '0;
  logic [7:0] mcu_wdata = '0;
  logic [7:0] mcu_rdata;
  logic       mcu_irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  mbx_cpu_mcu_bridge dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .mcu_we(mcu_we), .mcu_addr(mcu_addr), .mcu_wdata(mcu_wdata),
    .mcu_rdata(mcu_rdata), .mcu_irq(mcu_irq)
  );

  // kind: 0 host write, 1 host read+check, 2 mcu write, 3 mcu read+check
  localparam int NV = 30;
  localparam logic [24:0] VEC [NV] = '{
    {2'd1, 3'd1, 8'h00, 8'h03, 4'd9},   // R9 status after reset
    {2'd3, 3'd2, 8'h00, 8'h02, 4'd7},   // R7 port C idle
    {2'd1, 3'd0, 8'h00, 8'h00, 4'd1},   // R1 reply empty
    {2'd0, 3'd0, 8'hA5, 8'h00, 4'd2},   // R2 host sends A5
    {2'd1, 3'd1, 8'h00, 8'h01, 4'd2},   // R2 accept cleared
    {2'd3, 3'd2, 8'h00, 8'h03, 4'd7},   // R7 port C shows pending
    {2'd2, 3'd5, 8'h06, 8'h00, 4'd4},   // port B dir bits 1,2
    {2'd2, 3'd1, 8'h00, 8'h00, 4'd3},   // R3 strobe low
    {2'd3, 3'd0, 8'h00, 8'hA5, 4'd3},   // R3 port A input holds A5
    {2'd2, 3'd1, 8'h02, 8'h00, 4'd4},   // R4 rising bit 1
    {2'd1, 3'd1, 8'h00, 8'h03, 4'd4},   // R4 accept set
    {2'd2, 3'd0, 8'h3C, 8'h00, 4'd5},   // port A out 3C
    {2'd2, 3'd4, 8'hF0, 8'h00, 4'd8},   // port A dir F0
    {2'd3, 3'd0, 8'h00, 8'h35, 4'd8},   // R8 mixed read
    {2'd2, 3'd1, 8'h06, 8'h00, 4'd5},   // R5 rising bit 2
    {2'd1, 3'd1, 8'h00, 8'h02, 4'd5},   // R5 ready cleared
    {2'd3, 3'd2, 8'h00, 8'h00, 4'd7},   // R7 port C
    {2'd1, 3'd0, 8'h00, 8'h3C, 4'd6},   // R6 reply
    {2'd1, 3'd1, 8'h00, 8'h03, 4'd6},   // R6 ready set
    {2'd2, 3'd2, 8'h0A, 8'h00, 4'd8},   // port C out
    {2'd2, 3'd6, 8'h0F, 8'h00, 4'd8},   // port C dir
    {2'd3, 3'd2, 8'h00, 8'h0A, 4'd8},   // R8 port C mixed
    {2'd2, 3'd5, 8'h00, 8'h00, 4'd4},   // port B dir cleared
    {2'd0, 3'd0, 8'h11, 8'h00, 4'd2},   // R2 host sends 11
    {2'd2, 3'd1, 8'h00, 8'h00, 4'd3},   // R3 low ignored
    {2'd2, 3'd1, 8'h02, 8'h00, 4'd4},   // R4 rise ignored
    {2'd1, 3'd1, 8'h00, 8'h01, 4'd4},   // R4 accept still 0
    {2'd3, 3'd0, 8'h00, 8'h35, 4'd3},   // R3 no copy of 11
    {2'd1, 3'd2, 8'h00, 8'hFF, 4'd10},  // R10 clear reads FF
    {2'd1, 3'd1, 8'h00, 8'h03, 4'd10}   // R10 both flags set
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    host_wr = 0; host_rd = 0; mcu_we = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check("R1 irq", {7'd0, mcu_irq}, 8'h00);
    mcu_addr = 3'd2; #1;
    check("R1 portC", mcu_rdata, 8'h02);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      host_wr = 0; host_rd = 0; mcu_we = 0;
      case (VEC[i][24:23])
        2'd0: begin host_wr = 1; host_addr = VEC[i][21:20]; host_wdata = VEC[i][19:12]; end
        2'd1: begin host_rd = 1; host_addr = VEC[i][21:20]; end
        2'd2: begin mcu_we = 1; mcu_addr = VEC[i][22:20]; mcu_wdata = VEC[i][19:12]; end
        default: begin mcu_addr = VEC[i][22:20]; end
      endcase
      #1;
      if (VEC[i][24:23] == 2'd1)
        check($sformatf("R%0d vec%0d", VEC[i][3:0], i), host_rdata, VEC[i][11:4]);
      else if (VEC[i][24:23] == 2'd3)
        check($sformatf("R%0d vec%0d", VEC[i][3:0], i), mcu_rdata, VEC[i][11:4]);
    end
    idle();
    #1;
    check("R10 irq low", {7'd0, mcu_irq}, 8'h00);

    // R2: interrupt follows a host write
    host_wr = 1; host_addr = 2'd0; host_wdata = 8'h55;
    idle(); #1;
    check("R2 irq high", {7'd0, mcu_irq}, 8'h01);

    // prepare port B: direction bit 1 only, strobe low
    mcu_we = 1; mcu_addr = 3'd5; mcu_wdata = 8'h02;
    idle();
    mcu_we = 1; mcu_addr = 3'd1; mcu_wdata = 8'h00;
    idle();
    // R11: host write and accept edge in one cycle
    host_wr = 1; host_addr = 2'd0; host_wdata = 8'h77;
    mcu_we = 1; mcu_addr = 3'd1; mcu_wdata = 8'h02;
    idle();
    host_addr = 2'd1; #1;
    check("R11 status", host_rdata, 8'h01);
    check("R11 irq", {7'd0, mcu_irq}, 8'h01);

    // R4: a later clean edge accepts and drops the interrupt
    mcu_we = 1; mcu_addr = 3'd1; mcu_wdata = 8'h00;
    idle();
    mcu_we = 1; mcu_addr = 3'd1; mcu_wdata = 8'h02;
    idle(); #1;
    check("R4 status", host_rdata, 8'h03);
    check("R4 irq", {7'd0, mcu_irq}, 8'h00);
    mcu_addr = 3'd4; #1;
    check("R8 direction reg reads 0", mcu_rdata, 8'h00);

    // R1: mid-run reset restores idle state
    rst_n = 1'b0; #1;
    host_addr = 2'd1; #1;
    check("R1 status", host_rdata, 8'h03);
    check("R1 irq", {7'd0, mcu_irq}, 8'h00);
    host_addr = 2'd0; mcu_addr = 3'd0; #1;
    check("R1 reply", host_rdata, 8'h00);
    check("R1 portA", mcu_rdata, 8'h00);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule